// File: doc/BRIEF.md
# Frame Buffer Address Sequencer

This block drives the memory side of a display refresh path. When a frame-start pulse arrives it captures the geometry settings and walks a frame buffer that may be wider than the visible picture. For each display line it reads a view-width run of half-words, then jumps over an inter-line gap before it starts the next line. It stops when the address it would read next equals an end address that it computes itself from the base, the view width, the gap and the line count. It then raises a done flag and waits for the next frame-start pulse.

Reads are made one 32-bit word at a time over a request/acknowledge port, and only one request is open at any time. A fetched word can have its two 16-bit halves exchanged and its bytes reversed within each half. The word is then split into pixels, four 8-bit pixels or two 16-bit pixels, and these leave on a valid/ready stream with the lowest-addressed pixel first. Sync timing and colour lookup are handled elsewhere.

Addresses are in half-word units, 28 bits wide. The upper 7 bits form a bank field that stays fixed for the whole frame. The lower 21 bits advance and wrap inside that bank.

Top module: `fb_addr_seq`

## Requirements
- R1: After reset, rd_req, pix_valid and frame_done are all low.
- R2: A frame_start pulse seen while idle captures all settings. The first request of the frame then carries rd_addr = {bank_sel, base_lo}.
- R3: Inside a line, each word request is 2 half-words past the previous one. After page_width half-words, the next request is at the line's start plus page_width + gap_len.
- R4: The end address is base_lo + (page_width + gap_len) * (line_last + 1), taken modulo 2^21. When the advanced address equals it, the frame ends after the last pixel of the current word. frame_done is then high, and no further request or pixel appears. A frame therefore makes (page_width/2) * (line_last + 1) requests.
- R5: The lower 21 address bits wrap modulo 2^21 and never carry into rd_addr[27:21], which holds bank_sel for the whole frame.
- R6: Only one read is open at a time. rd_req and rd_addr hold until rd_ack. No new request is made while pixels of the current word are still pending.
- R7: When swap_halves is set, the fetched word's bits 31:16 and 15:0 are exchanged before unpacking.
- R8: When swap_bytes is set, the two bytes inside each 16-bit half are exchanged (after any half exchange).
- R9: pix_mode 4'b1011 selects 8 bpp. Each word gives four pixels, bits 7:0 first through 31:24 last, each zero-extended to 16 bits.
- R10: pix_mode 4'b1100, 4'b1110 and any other code select 16 bpp. Each word gives two pixels, bits 15:0 first and then 31:16.
- R11: While pix_valid is high and pix_ready is low, pix_valid and pix_data hold.
- R12: A frame_start pulse during an active frame is ignored, and the address sequence continues unchanged.
- R13: After frame_done, a new frame_start clears frame_done and restarts from the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that begins a frame when idle |
| bank_sel | input | 7 | Fixed upper address field |
| base_lo | input | 21 | Start half-word address inside the bank |
| page_width | input | 11 | Half-words shown per line |
| gap_len | input | 11 | Half-words skipped between lines |
| line_last | input | 10 | Number of lines minus one |
| pix_mode | input | 4 | Pixel format code |
| swap_halves | input | 1 | Exchange the 16-bit halves of each word |
| swap_bytes | input | 1 | Reverse the bytes within each half |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 28 | Half-word address of the requested word |
| rd_ack | input | 1 | Read accepted; rd_data valid in the same cycle |
| rd_data | input | 32 | Fetched word |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Consumer takes the pixel |
| pix_data | output | 16 | Pixel value |
| frame_done | output | 1 | Frame finished; waiting for frame_start |

## Verification
The assertions assume that rd_ack arrives only while rd_req is high. They also assume that base_lo, page_width and gap_len are even, that page_width is at least 2, and that the frame span stays well below 2^21, so the end address cannot match partway through a frame. The stimulus draws only even values in small ranges and acknowledges only requests it has seen. It still puts a base near the top of the 21-bit space to force the wrap, and it inserts random gaps in both acknowledge and ready so that the hold rules are exercised.

// File: rtl/fbs_pkg.sv
// Package fbs_pkg
// Shared state type and pixel format codes for the frame buffer sequencer.
// Assumes nothing beyond the parameter defaults used by the top module.
package fbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } seq_state_t;

    localparam logic [3:0] MODE_BYTE_PIX = 4'b1011;
    localparam logic [3:0] MODE_HALF_PIX = 4'b1100;
    localparam logic [3:0] MODE_HALF_ALT = 4'b1110;

    // Only the 8 bpp code unpacks bytes; every other code unpacks half-words.
    function automatic logic is_byte_mode(input logic [3:0] code);
        return code == MODE_BYTE_PIX;
    endfunction

endpackage

// File: rtl/fbs_addr_gen.sv
// Module fbs_addr_gen
// Holds the current half-word address inside the bank, steps it one word at
// a time across a line and jumps the inter-line gap at each line end. It
// computes the end address once at load and flags when the address reaches it.
// Assumes base, width and gap are even and width is at least 2.
module fbs_addr_gen #(
    parameter int LOW_W  = 21,
    parameter int SPAN_W = 11,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [LOW_W-1:0]  base_lo,
    input  logic [SPAN_W-1:0] page_width,
    input  logic [SPAN_W-1:0] gap_len,
    input  logic [LINE_W-1:0] line_last,
    output logic [LOW_W-1:0]  cur_lo,
    output logic              at_end
);
    localparam int PITCH_W = SPAN_W + 1;
    localparam int LINES_W = LINE_W + 1;
    localparam int PROD_W  = PITCH_W + LINES_W;

    logic [LOW_W-1:0]   cur_q, end_q;
    logic [SPAN_W-1:0]  col_q, width_q, gap_q;
    logic [PITCH_W-1:0] pitch;
    logic [LINES_W-1:0] lines;
    logic [PROD_W-1:0]  span_total;
    logic [LOW_W-1:0]   end_calc;
    logic               line_end;

    // End address from the live settings, used only on load.
    always_comb begin
        pitch      = {1'b0, page_width} + {1'b0, gap_len};
        lines      = {1'b0, line_last} + LINES_W'(1);
        span_total = PROD_W'(pitch) * PROD_W'(lines);
        end_calc   = base_lo + LOW_W'(span_total);
    end

    // The current word is the last one of its line.
    assign line_end = ({1'b0, col_q} + PITCH_W'(2)) >= {1'b0, width_q};

    // Address and column counters; the low field wraps modulo 2^LOW_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            end_q   <= '0;
            col_q   <= '0;
            width_q <= '0;
            gap_q   <= '0;
        end else if (load) begin
            cur_q   <= base_lo;
            end_q   <= end_calc;
            col_q   <= '0;
            width_q <= page_width;
            gap_q   <= gap_len;
        end else if (step) begin
            if (line_end) begin
                cur_q <= cur_q + LOW_W'(2) + LOW_W'(gap_q);
                col_q <= '0;
            end else begin
                cur_q <= cur_q + LOW_W'(2);
                col_q <= col_q + SPAN_W'(2);
            end
        end
    end

    assign cur_lo = cur_q;
    assign at_end = (cur_q == end_q);

endmodule

// File: rtl/fbs_swap.sv
// Module fbs_swap
// Optional exchange of the two halves of a word, followed by optional
// reversal of the bytes inside each half. Purely combinational.
// Assumes DATA_W is a multiple of 16.
module fbs_swap #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic              half_swap,
    input  logic              byte_swap,
    output logic [DATA_W-1:0] dout
);
    localparam int HALF_W = DATA_W / 2;
    localparam int BPH    = HALF_W / 8;

    logic [DATA_W-1:0] halved;

    // Stage one: exchange the upper and lower halves.
    assign halved = half_swap ? {din[HALF_W-1:0], din[DATA_W-1:HALF_W]} : din;

    // Stage two: mirror the byte order inside each half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        for (genvar b = 0; b < BPH; b++) begin : g_byte
            assign dout[h*HALF_W + b*8 +: 8] = byte_swap
                ? halved[h*HALF_W + (BPH-1-b)*8 +: 8]
                : halved[h*HALF_W + b*8 +: 8];
        end
    end

endmodule

// File: rtl/fbs_pix_sel.sv
// Module fbs_pix_sel
// Picks one pixel out of a held 32-bit word: a byte lane zero-extended in
// 8 bpp, or a half-word lane in 16 bpp. Lane 0 is the lowest address.
// Assumes a 32-bit word and a 16-bit pixel bus.
module fbs_pix_sel #(
    parameter int DATA_W = 32,
    parameter int PIX_W  = 16
) (
    input  logic [DATA_W-1:0] word,
    input  logic [1:0]        idx,
    input  logic              byte_mode,
    output logic [PIX_W-1:0]  pix
);
    logic [7:0]       byte_lane;
    logic [PIX_W-1:0] half_lane;

    // Lane selection for both formats, then format choice.
    always_comb begin
        byte_lane = word[{idx, 3'b000} +: 8];
        half_lane = word[{idx[0], 4'b0000} +: PIX_W];
        pix       = byte_mode ? {{(PIX_W-8){1'b0}}, byte_lane} : half_lane;
    end

endmodule

// File: rtl/fb_addr_seq.sv
// Module fb_addr_seq
// Streams one frame: requests words in view/gap order, swaps and unpacks them
// into pixels, stops at the computed end address and waits for frame_start.
// Assumes rd_ack only while rd_req is high, even geometry and width >= 2.
module fb_addr_seq
    import fbs_pkg::*;
#(
    parameter int BANK_W = 7,
    parameter int LOW_W  = 21,
    parameter int SPAN_W = 11,
    parameter int LINE_W = 10,
    parameter int DATA_W = 32,
    parameter int PIX_W  = 16,
    localparam int ADDR_W = BANK_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [LOW_W-1:0]  base_lo,
    input  logic [SPAN_W-1:0] page_width,
    input  logic [SPAN_W-1:0] gap_len,
    input  logic [LINE_W-1:0] line_last,
    input  logic [3:0]        pix_mode,
    input  logic              swap_halves,
    input  logic              swap_bytes,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [PIX_W-1:0]  pix_data,
    output logic              frame_done
);
    seq_state_t        state_q;
    logic [BANK_W-1:0] bank_q;
    logic              byte_mode_q, hs_q, bs_q, done_q;
    logic [DATA_W-1:0] word_q, swapped;
    logic [1:0]        idx_q, last_idx;
    logic [LOW_W-1:0]  cur_lo;
    logic              at_end, load, step;

    assign load     = (state_q == ST_IDLE) && frame_start;
    assign step     = (state_q == ST_FETCH) && rd_ack;
    assign last_idx = byte_mode_q ? 2'd3 : 2'd1;

    fbs_addr_gen #(.LOW_W(LOW_W), .SPAN_W(SPAN_W), .LINE_W(LINE_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .base_lo    (base_lo),
        .page_width (page_width),
        .gap_len    (gap_len),
        .line_last  (line_last),
        .cur_lo     (cur_lo),
        .at_end     (at_end)
    );

    fbs_swap #(.DATA_W(DATA_W)) u_swap (
        .din       (rd_data),
        .half_swap (hs_q),
        .byte_swap (bs_q),
        .dout      (swapped)
    );

    fbs_pix_sel #(.DATA_W(DATA_W), .PIX_W(PIX_W)) u_sel (
        .word      (word_q),
        .idx       (idx_q),
        .byte_mode (byte_mode_q),
        .pix       (pix_data)
    );

    // Frame control: capture settings, fetch a word, drain its pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            bank_q      <= '0;
            byte_mode_q <= 1'b0;
            hs_q        <= 1'b0;
            bs_q        <= 1'b0;
            done_q      <= 1'b0;
            word_q      <= '0;
            idx_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (frame_start) begin
                        bank_q      <= bank_sel;
                        byte_mode_q <= is_byte_mode(pix_mode);
                        hs_q        <= swap_halves;
                        bs_q        <= swap_bytes;
                        done_q      <= 1'b0;
                        state_q     <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (rd_ack) begin
                        word_q  <= swapped;
                        idx_q   <= '0;
                        state_q <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (pix_ready) begin
                        if (idx_q == last_idx) begin
                            if (at_end) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                state_q <= ST_FETCH;
                            end
                        end else begin
                            idx_q <= idx_q + 2'd1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_req     = (state_q == ST_FETCH);
    assign rd_addr    = {bank_q, cur_lo};
    assign pix_valid  = (state_q == ST_EMIT);
    assign frame_done = done_q;

endmodule

// File: rtl/fbs_checker.sv
// Module fbs_checker
// Protocol properties of the sequencer, observed at its ports and bound to
// every instance of fb_addr_seq. Assumes rd_ack only while rd_req is high.
module fbs_checker #(
    parameter int ADDR_W = 28,
    parameter int PIX_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic [PIX_W-1:0]  pix_data,
    input logic              frame_done
);
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    p_one_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && pix_valid));

    p_pix_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_data));

    p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !rd_req && !pix_valid);

    p_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && frame_start |=> rd_req && !frame_done);

    p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && $past(rd_req) |-> rd_addr[ADDR_W-1:ADDR_W-7] == $past(rd_addr[ADDR_W-1:ADDR_W-7]));

endmodule

bind fb_addr_seq fbs_checker #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_fbs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .rd_req      (rd_req),
    .rd_ack      (rd_ack),
    .rd_addr     (rd_addr),
    .pix_valid   (pix_valid),
    .pix_ready   (pix_ready),
    .pix_data    (pix_data),
    .frame_done  (frame_done)
);

// File: tb/tb_fb_addr_seq.sv
// Bench for fb_addr_seq: directed corner frames plus seeded random frames.
// Memory answers with an address-derived word after random delays.
module tb_fb_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [6:0]  bank_sel = '0;
    logic [20:0] base_lo = '0;
    logic [10:0] page_width = '0;
    logic [10:0] gap_len = '0;
    logic [9:0]  line_last = '0;
    logic [3:0]  pix_mode = '0;
    logic        swap_halves = 1'b0;
    logic        swap_bytes = 1'b0;
    logic        rd_req;
    logic [27:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic [15:0] pix_data;
    logic        frame_done;

    int errors = 0;
    int checks = 0;
    logic [31:0] cur_word;

    always #5 clk = ~clk;

    fb_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .bank_sel(bank_sel), .base_lo(base_lo), .page_width(page_width),
        .gap_len(gap_len), .line_last(line_last), .pix_mode(pix_mode),
        .swap_halves(swap_halves), .swap_bytes(swap_bytes),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [27:0] a);
        return 32'({4'h0, a} * 32'h9E3779B1) ^ 32'h13579BDF;
    endfunction

    function automatic logic [31:0] swap_ref(input logic [31:0] w, input bit hs, input bit bs);
        logic [31:0] t;
        t = hs ? {w[15:0], w[31:16]} : w;
        if (bs) t = {t[23:16], t[31:24], t[7:0], t[15:8]};
        return t;
    endfunction

    function automatic logic [15:0] pix_ref(input logic [31:0] w, input int k, input bit bytes);
        if (bytes) return {8'h00, w[8*k +: 8]};
        return w[16*k +: 16];
    endfunction

    function automatic logic [27:0] addr_ref(input logic [6:0] bk, input int base, input int pw,
                                             input int sk, input int k);
        int per_line, line, col;
        per_line = pw / 2;
        line = k / per_line;
        col  = k % per_line;
        return {bk, 21'(base + line * (pw + sk) + 2 * col)};
    endfunction

    // One frame: configure, pulse start, serve reads, check every output.
    task automatic run_frame(input logic [6:0] bk, input int base, input int pw, input int sk,
                             input int lc, input logic [3:0] md, input bit hs, input bit bs,
                             input int restart_at);
        int total, words, pidx, cyc, npix;
        bit bytes;
        bytes = (md == 4'b1011);
        npix  = bytes ? 4 : 2;
        total = (pw / 2) * (lc + 1);
        words = 0; pidx = 0; cyc = 0;
        bank_sel = bk; base_lo = 21'(base); page_width = 11'(pw); gap_len = 11'(sk);
        line_last = 10'(lc); pix_mode = md; swap_halves = hs; swap_bytes = bs;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        while (!frame_done && cyc < 6000) begin
            rd_ack = 1'b0;
            if (rd_req) begin
                if (words >= total) begin
                    check(0, "R4 request beyond end", longint'(words), longint'(total));
                end else begin
                    check(rd_addr == addr_ref(bk, base, pw, sk, words),
                          words == 0 ? "R2 R13 first address" : "R3 R5 R12 address",
                          longint'(rd_addr), longint'(addr_ref(bk, base, pw, sk, words)));
                    rd_data = mem_word(rd_addr);
                    if (($urandom % 4) != 0) begin
                        rd_ack = 1'b1;
                        cur_word = swap_ref(rd_data, hs, bs);
                        words++;
                        pidx = 0;
                    end
                end
            end
            if (pix_valid) begin
                check(pidx < npix, "R6 R9 R10 pixel count", longint'(pidx), longint'(npix));
                check(pix_data == pix_ref(cur_word, pidx, bytes), "R7 R8 R9 R10 R11 pixel",
                      longint'(pix_data), longint'(pix_ref(cur_word, pidx, bytes)));
                pix_ready = (($urandom % 3) != 0);
                if (pix_ready) pidx++;
            end else begin
                pix_ready = $urandom % 2;
            end
            frame_start = (cyc == restart_at);
            cyc++;
            @(negedge clk);
        end
        frame_start = 1'b0;
        rd_ack = 1'b0;
        check(frame_done, "R4 frame finished", longint'(frame_done), 1);
        check(words == total, "R4 word count", longint'(words), longint'(total));
        repeat (3) @(negedge clk);
        check(frame_done && !rd_req && !pix_valid, "R4 idle after end",
              longint'({frame_done, rd_req, pix_valid}), 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(!rd_req && !pix_valid && !frame_done, "R1 reset outputs",
              longint'({rd_req, pix_valid, frame_done}), 0);
        // Directed corners
        run_frame(7'h55, 32'h100, 8, 4, 2, 4'b1100, 0, 0, -1);      // R10 R3
        run_frame(7'h55, 32'h100, 8, 4, 2, 4'b1011, 1, 0, -1);      // R9 R7
        run_frame(7'h2A, 32'h2000, 10, 6, 3, 4'b1100, 0, 1, -1);    // R8
        run_frame(7'h01, 32'h40, 6, 2, 1, 4'b1110, 1, 1, -1);       // R10 alt code
        run_frame(7'h7F, 32'h1FFFF8, 6, 2, 3, 4'b1100, 0, 0, -1);   // R5 wrap
        run_frame(7'h33, 32'h1FFFFE, 2, 0, 0, 4'b1011, 0, 0, -1);   // one-word frame
        run_frame(7'h12, 32'h800, 12, 8, 4, 4'b1100, 0, 0, 5);      // R12 start mid-frame
        run_frame(7'h12, 32'h800, 12, 8, 4, 4'b1011, 1, 1, 17);     // R12 R13 restart
        // Random frames
        for (int f = 0; f < 24; f++) begin
            int pw, sk, lc, base, mi, rs;
            logic [3:0] md;
            pw   = 2 * (1 + int'($urandom % 16));
            sk   = 2 * int'($urandom % 21);
            lc   = int'($urandom % 7);
            base = int'($urandom % 32'h200000) & ~1;
            mi   = int'($urandom % 4);
            md   = (mi == 0) ? 4'b1011 : (mi == 1) ? 4'b1100 : (mi == 2) ? 4'b1110 : 4'b0101;
            rs   = (($urandom % 3) == 0) ? int'($urandom % 20) : -1;
            run_frame(7'($urandom), base, pw, sk, lc, md, 1'($urandom), 1'($urandom), rs);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule